// File: doc/BRIEF.md
# Multiply/Divide Coprocessor

This block is an unsigned arithmetic helper that sits beside an 8-bit CPU on its special-function-register bus. The CPU loads operands byte by byte into six operand/result registers. The order of those writes selects the operation: a 32/16 division, a 16x16 multiplication, or a 32-bit shift or normalize. The block then works one bit per clock. When it finishes, the results overwrite the operand bytes, and the CPU reads them back from the same addresses.

A control/status byte holds the shift count, the shift direction, an overflow flag and an error flag. The error flag catches software that starts a new calculation before it has read the final result byte of the previous one. This lets a task that shares the unit find out that its results were lost.

Top module: `mdu_copro`

## Requirements
- R1: After reset, every register at E9h..EFh reads 00h. Operand bytes MD0..MD5 sit at E9h..EEh with MD0 as the least significant byte. The control byte sits at EFh and reads as {error, overflow, direction, count[4:0]}, with the error flag in bit 7 and the overflow flag in bit 6.
- R2: Writing MD0, MD1, MD2, MD3, MD4, MD5 in that order starts a division of {MD3..MD0} by {MD5,MD4}. When it completes, the quotient is in MD3..MD0, the remainder is in MD5:MD4, and bit 6 is 0.
- R3: A division by zero sets bit 6. It leaves quotient FFFFFFFFh and a remainder equal to the low 16 bits of the dividend.
- R4: Writing MD0, MD4, MD1, MD5 in that order multiplies {MD1,MD0} by {MD5,MD4} and puts the 32-bit product in MD3..MD0. Bit 6 is set exactly when the product exceeds FFFFh.
- R5: Writing MD0..MD3 and then the control byte with a nonzero count in bits 4:0 shifts {MD3..MD0} by that count. The shift goes right when bit 5 is 1 and left when bit 5 is 0. Vacated bits are zero.
- R6: The same sequence with a count of 0 normalizes the value: it shifts left until bit 31 is 1 and writes the number of shifts into bits 4:0. An all-zero value stays zero and sets bit 6.
- R7: The overflow flag is cleared when a new operation starts.
- R8: Until an operation completes, reads return the operand values, and writes to MD0..MD5 or to the control byte are ignored.
- R9: Writing MD0 while error monitoring is armed sets bit 7. The first MD0 write arms monitoring. A write to the control byte cannot set or clear bit 7.
- R10: Reading the final result byte after completion disarms monitoring. The final byte is MD5 for division and MD3 for the other operations. A following MD0 write then leaves bit 7 clear.
- R11: Reading the control byte clears bit 7. The read itself returns the value before clearing.
- R12: A write order matching none of the three sequences starts nothing, and the written bytes stay readable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Write strobe, one cycle per byte |
| sfr_rd | input | 1 | Read strobe, one cycle per byte |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for the addressed register, combinational |

## Verification
Division is run with an ordinary dividend and divisor, with a zero divisor, and with a dividend that is read and overwritten while the calculation runs. Together these separate the quotient and remainder paths, the zero-divisor result and the busy-time protection. Multiplication uses a small product and an all-ones product, which separates a correct product from a wrong overflow flag. The shift tests cover left and right shifts with a short count and with the maximum count, and the normalize tests cover a value with fifteen leading zeros and a zero value. An out-of-order write sequence and a restarted sequence check that the order decoder and the error flag react only to the sequences they are meant to.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  localparam int DW  = 32;          // dividend / product / shift width
  localparam int HW  = DW / 2;      // divisor / factor width
  localparam int SCW = $clog2(DW);  // shift count width
  localparam int CW  = SCW + 1;     // iteration counter width
  localparam int NMD = 6;           // operand/result bytes

  typedef enum logic [2:0] {
    OP_NONE, OP_DIV, OP_MUL, OP_SHL, OP_SHR, OP_NORM
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_W0, SQ_D1, SQ_D2, SQ_D3, SQ_D4, SQ_M4, SQ_M1
  } seq_e;
endpackage

// File: rtl/mdu_order.sv
`timescale 1ns/1ps
// Decodes the order of accepted register writes into an operation start.
module mdu_order
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [2:0] wr_idx,
  input  logic [5:0] ctl_bits,
  output logic       start,
  output op_e        op
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    op      = OP_NONE;
    if (wr_ok) begin
      state_d = SQ_IDLE;
      case (wr_idx)
        3'd0: state_d = SQ_W0;
        3'd1: if (state_q == SQ_W0) state_d = SQ_D1;
              else if (state_q == SQ_M4) state_d = SQ_M1;
        3'd2: if (state_q == SQ_D1) state_d = SQ_D2;
        3'd3: if (state_q == SQ_D2) state_d = SQ_D3;
        3'd4: if (state_q == SQ_D3) state_d = SQ_D4;
              else if (state_q == SQ_W0) state_d = SQ_M4;
        3'd5: if (state_q == SQ_D4) begin
                start = 1'b1; op = OP_DIV;
              end else if (state_q == SQ_M1) begin
                start = 1'b1; op = OP_MUL;
              end
        3'd6: if (state_q == SQ_D3) begin
                start = 1'b1;
                if (ctl_bits[4:0] == 5'd0) op = OP_NORM;
                else if (ctl_bits[5])      op = OP_SHR;
                else                       op = OP_SHL;
              end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;

  // Every start ends the sequence (R2, R4, R5)
  assert_seq_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/mdu_engine.sv
`timescale 1ns/1ps
// Iterative datapath: one quotient bit, product bit or shift step per clock.
module mdu_engine
  import mdu_pkg::*;
#(
  parameter int W   = DW,
  parameter int H   = W / 2,
  parameter int SW  = $clog2(W),
  parameter int CNW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  op_e           op_in,
  input  logic [W-1:0]  opa,
  input  logic [H-1:0]  opb,
  input  logic [SW-1:0] sc_in,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  res,
  output logic [H-1:0]  rem,
  output logic [SW-1:0] sc_out,
  output logic          ovf
);
  op_e            op_q, op_d;
  logic [W-1:0]   x_q, x_d;
  logic [H-1:0]   r_q, r_d, b_q, b_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           busy_q, busy_d, done_q, done_d, ovf_q, ovf_d;
  logic [H:0]     sh, dif, sum;
  logic           ge, fin;

  always_comb begin
    op_d = op_q; x_d = x_q; r_d = r_q; b_d = b_q; cnt_d = cnt_q;
    busy_d = busy_q; done_d = 1'b0; ovf_d = ovf_q;
    sh  = {r_q, x_q[W-1]};
    dif = sh - {1'b0, b_q};
    ge  = (sh >= {1'b0, b_q});
    sum = {1'b0, r_q} + (x_q[0] ? {1'b0, b_q} : '0);
    fin = (op_q == OP_NORM) ? (x_q[W-1] || x_q == '0) : (cnt_q == '0);
    if (load) begin
      op_d   = op_in;
      busy_d = 1'b1;
      ovf_d  = 1'b0;
      r_d    = '0;
      x_d    = (op_in == OP_MUL) ? {{(W-H){1'b0}}, opb} : opa;
      b_d    = (op_in == OP_MUL) ? opa[H-1:0] : opb;
      case (op_in)
        OP_DIV:         cnt_d = CNW'(W);
        OP_MUL:         cnt_d = CNW'(H);
        OP_SHL, OP_SHR: cnt_d = {1'b0, sc_in};
        default:        cnt_d = '0;
      endcase
    end else if (busy_q) begin
      if (fin) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        case (op_q)
          OP_DIV:  ovf_d = (b_q == '0);
          OP_MUL:  begin ovf_d = (r_q != '0); x_d = {r_q, x_q[H-1:0]}; end
          OP_NORM: ovf_d = (x_q == '0);
          default: ovf_d = 1'b0;
        endcase
      end else begin
        case (op_q)
          OP_DIV: begin
            r_d   = ge ? dif[H-1:0] : sh[H-1:0];
            x_d   = {x_q[W-2:0], ge};
            cnt_d = cnt_q - 1'b1;
          end
          OP_MUL: begin
            r_d   = sum[H:1];
            x_d   = {x_q[W-1:H], sum[0], x_q[H-1:1]};
            cnt_d = cnt_q - 1'b1;
          end
          OP_SHL:  begin x_d = x_q << 1; cnt_d = cnt_q - 1'b1; end
          OP_SHR:  begin x_d = x_q >> 1; cnt_d = cnt_q - 1'b1; end
          OP_NORM: begin x_d = x_q << 1; cnt_d = cnt_q + 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_q <= OP_NONE; x_q <= '0; r_q <= '0; b_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      op_q <= op_d; x_q <= x_d; r_q <= r_d; b_q <= b_d; cnt_q <= cnt_d;
      busy_q <= busy_d; done_q <= done_d; ovf_q <= ovf_d;
    end

  assign busy   = busy_q;
  assign done   = done_q;
  assign res    = x_q;
  assign rem    = r_q;
  assign sc_out = cnt_q[SW-1:0];
  assign ovf    = ovf_q;

  // The control logic never loads a new job while one is running (R8)
  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
  // A successful normalize ends with the top bit set (R6)
  assert_norm_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_NORM && !ovf_q) |-> x_q[W-1]);
  // A zero divisor yields an all-ones quotient (R3)
  assert_div0_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_DIV && ovf_q) |-> (&x_q));
endmodule

// File: rtl/mdu_copro.sv
`timescale 1ns/1ps
// Register-mapped multiply/divide/shift coprocessor.
module mdu_copro
  import mdu_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'hE9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata
);
  localparam logic [2:0] CTL_IDX = 3'(NMD);

  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_s = rs_q[1];

  logic [7:0] idx_full;
  logic [2:0] idx, fin_idx;
  logic       hit, busy_all, wr_ok, wr_md0, rd_fin, rd_ctl;
  assign idx_full = sfr_addr - ADDR_BASE;
  assign idx      = idx_full[2:0];
  assign hit      = (idx_full <= 8'(NMD));

  logic [NMD-1:0][7:0] md_q, md_d;
  logic [SCW-1:0]      sc_q, sc_d;
  logic slr_q, slr_d, mdov_q, mdov_d, mdef_q, mdef_d;
  logic armed_q, armed_d, rdy_q, rdy_d, start_q;
  op_e  op_q, op_d, seq_op;
  logic seq_start;

  logic            core_busy, core_done, core_ovf;
  logic [DW-1:0]   core_res;
  logic [HW-1:0]   core_rem;
  logic [SCW-1:0]  core_sc;

  assign busy_all = start_q | core_busy | core_done;
  assign wr_ok    = sfr_wr & hit & ~busy_all;
  assign wr_md0   = sfr_wr & hit & (idx == 3'd0);
  assign fin_idx  = (op_q == OP_DIV) ? 3'd5 : 3'd3;
  assign rd_fin   = sfr_rd & hit & ~busy_all & rdy_q & (idx == fin_idx);
  assign rd_ctl   = sfr_rd & hit & (idx == CTL_IDX);

  mdu_order u_order (
    .clk(clk), .rst_n(rst_s), .wr_ok(wr_ok), .wr_idx(idx),
    .ctl_bits(sfr_wdata[5:0]), .start(seq_start), .op(seq_op)
  );

  mdu_engine #(.W(DW)) u_engine (
    .clk(clk), .rst_n(rst_s), .load(start_q), .op_in(op_q),
    .opa(md_q[3:0]), .opb(md_q[5:4]), .sc_in(sc_q),
    .busy(core_busy), .done(core_done), .res(core_res), .rem(core_rem),
    .sc_out(core_sc), .ovf(core_ovf)
  );

  always_comb begin
    md_d = md_q; sc_d = sc_q; slr_d = slr_q; mdov_d = mdov_q;
    op_d = op_q; rdy_d = rdy_q;
    for (int i = 0; i < NMD; i++)
      if (wr_ok && idx == 3'(i)) md_d[i] = sfr_wdata;
    if (wr_ok && idx == CTL_IDX) {slr_d, sc_d} = sfr_wdata[5:0];
    if (core_done) begin
      md_d[3:0] = core_res;
      if (op_q == OP_DIV)  md_d[5:4] = core_rem;
      if (op_q == OP_NORM) sc_d = core_sc;
      mdov_d = core_ovf;
      rdy_d  = 1'b1;
    end
    if (seq_start) begin
      op_d   = seq_op;
      mdov_d = 1'b0;
      rdy_d  = 1'b0;
    end
    if (rd_fin) rdy_d = 1'b0;
    armed_d = wr_md0 ? 1'b1 : (rd_fin ? 1'b0 : armed_q);
    mdef_d  = (wr_md0 && armed_q) ? 1'b1 : (rd_ctl ? 1'b0 : mdef_q);
  end

  always_ff @(posedge clk or negedge rst_s)
    if (!rst_s) begin
      md_q <= '0; sc_q <= '0; slr_q <= 1'b0; mdov_q <= 1'b0; mdef_q <= 1'b0;
      armed_q <= 1'b0; rdy_q <= 1'b0; start_q <= 1'b0; op_q <= OP_NONE;
    end else begin
      md_q <= md_d; sc_q <= sc_d; slr_q <= slr_d; mdov_q <= mdov_d;
      mdef_q <= mdef_d; armed_q <= armed_d; rdy_q <= rdy_d;
      start_q <= seq_start; op_q <= op_d;
    end

  always_comb begin
    sfr_rdata = 8'h00;
    if (hit) begin
      if (idx == CTL_IDX) sfr_rdata = {mdef_q, mdov_q, slr_q, sc_q};
      for (int i = 0; i < NMD; i++)
        if (idx == 3'(i)) sfr_rdata = md_q[i];
    end
  end

  // A job being loaded never sees a stale overflow flag (R7)
  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_s)
    start_q |-> !mdov_q);
  // Operand bytes hold while a job runs (R8)
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_all && !core_done) |=> $stable(md_q));
  // A restart while armed raises the error flag (R9)
  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_md0 && armed_q) |=> mdef_q);
  // Reading the control byte clears the error flag (R11)
  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_ctl && !sfr_wr) |=> !mdef_q);
endmodule

// File: tb/tb_mdu_copro.sv
`timescale 1ns/1ps
module tb_mdu_copro;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic       sfr_wr = 1'b0, sfr_rd = 1'b0;
  logic [7:0] sfr_rdata;

  always #4 clk = ~clk;  // 125 MHz

  mdu_copro dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  localparam logic [7:0] A_MD0 = 8'hE9, A_MD1 = 8'hEA, A_MD2 = 8'hEB,
                         A_MD3 = 8'hEC, A_MD4 = 8'hED, A_MD5 = 8'hEE,
                         A_CTL = 8'hEF;

  int total = 0;
  int bad = 0;

  // scoreboard
  logic [7:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];
  logic [7:0] m_exp;
  bit         m_chk;
  string      m_tag;

  always @(negedge clk) begin
    if (sfr_rd) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL monitor: read with no expected item, actual=%h expected=none", sfr_rdata);
      end else begin
        m_exp = exp_q.pop_front();
        m_chk = chk_q.pop_front();
        m_tag = tag_q.pop_front();
        if (m_chk) begin
          total++;
          if (sfr_rdata !== m_exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", m_tag, sfr_addr, sfr_rdata, m_exp);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(posedge clk); #1;
    sfr_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); chk_q.push_back(1'b1); tag_q.push_back(t);
    @(posedge clk); #1;
    sfr_addr = a; sfr_rd = 1'b1;
    @(posedge clk); #1;
    sfr_rd = 1'b0;
  endtask

  task automatic wait_op();
    repeat (45) @(posedge clk);
  endtask

  task automatic load32(input logic [31:0] v);
    wr(A_MD0, v[7:0]); wr(A_MD1, v[15:8]); wr(A_MD2, v[23:16]); wr(A_MD3, v[31:24]);
  endtask

  task automatic chk32(input logic [31:0] v, input string t);
    rd(A_MD0, v[7:0], t); rd(A_MD1, v[15:8], t); rd(A_MD2, v[23:16], t); rd(A_MD3, v[31:24], t);
  endtask

  task automatic do_div(input logic [31:0] dvd, input logic [15:0] dvs, input string t);
    logic [31:0] q;
    logic [15:0] r;
    if (dvs == 16'd0) begin q = 32'hFFFF_FFFF; r = dvd[15:0]; end
    else begin q = dvd / {16'd0, dvs}; r = 16'(dvd % {16'd0, dvs}); end
    load32(dvd); wr(A_MD4, dvs[7:0]); wr(A_MD5, dvs[15:8]);
    wait_op();
    chk32(q, t); rd(A_MD4, r[7:0], t); rd(A_MD5, r[15:8], t);
  endtask

  task automatic do_mul(input logic [15:0] a, input logic [15:0] b, input string t);
    logic [31:0] p;
    p = {16'd0, a} * {16'd0, b};
    wr(A_MD0, a[7:0]); wr(A_MD4, b[7:0]); wr(A_MD1, a[15:8]); wr(A_MD5, b[15:8]);
    wait_op();
    chk32(p, t);
  endtask

  function automatic int lead_zeros(input logic [31:0] v);
    int n = 0;
    while (n < 32 && v[31 - n] == 1'b0) n++;
    return n;
  endfunction

  initial begin
    int nz;
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    for (int a = 8'hE9; a <= 8'hEF; a++) rd(8'(a), 8'h00, "R1 reset value");

    // R2: ordinary division
    do_div(32'h1234_5678, 16'h1234, "R2 division");
    rd(A_CTL, 8'h00, "R2 no overflow");

    // R3: divide by zero
    do_div(32'hCAFE_BABE, 16'h0000, "R3 divide by zero");
    rd(A_CTL, 8'h40, "R3 overflow set");

    // R4 + R7: small product clears overflow
    do_mul(16'h00FF, 16'h0010, "R4 small product");
    rd(A_CTL, 8'h00, "R7 overflow cleared by new op");

    // R4: large product flags overflow
    do_mul(16'hFFFF, 16'hFFFF, "R4 large product");
    rd(A_CTL, 8'h40, "R4 product overflow");

    // R8: reads during calculation show operands, writes ignored
    load32(32'hDEAD_BEEF); wr(A_MD4, 8'hFF); wr(A_MD5, 8'h00);
    rd(A_MD0, 8'hEF, "R8 operand visible while busy");
    rd(A_MD3, 8'hDE, "R8 operand visible while busy");
    wr(A_MD1, 8'h55);
    wait_op();
    chk32(32'hDEAD_BEEF / 32'h0000_00FF, "R8 write during busy ignored");
    rd(A_MD4, 8'(32'hDEAD_BEEF % 32'h0000_00FF), "R8 remainder");
    rd(A_MD5, 8'h00, "R8 remainder");
    rd(A_CTL, 8'h00, "R7 overflow cleared");

    // R5: left shift by 4
    load32(32'h0000_0081); wr(A_CTL, 8'h04);
    wait_op();
    chk32(32'h0000_0810, "R5 left shift");
    rd(A_CTL, 8'h04, "R5 count kept");

    // R5: right shift by 31
    load32(32'h8000_0000); wr(A_CTL, 8'h3F);
    wait_op();
    chk32(32'h0000_0001, "R5 right shift");
    rd(A_CTL, 8'h3F, "R5 direction kept");

    // R6: normalize
    v = 32'h0001_2345;
    nz = lead_zeros(v);
    load32(v); wr(A_CTL, 8'h00);
    wait_op();
    chk32(v << nz, "R6 normalize value");
    rd(A_CTL, 8'(nz), "R6 normalize count");

    // R6: normalize of zero
    load32(32'h0); wr(A_CTL, 8'h00);
    wait_op();
    chk32(32'h0, "R6 zero normalize value");
    rd(A_CTL, 8'h40, "R6 zero normalize overflow");

    // R9: error flag not writable
    wr(A_CTL, 8'h80);
    rd(A_CTL, 8'h40, "R9 error flag read-only");

    // R9: restart while armed, R11: cleared by read
    wr(A_MD0, 8'h10);
    wr(A_MD0, 8'h20);
    rd(A_CTL, 8'hC0, "R9 restart sets error");
    rd(A_CTL, 8'h40, "R11 error cleared by read");
    wr(A_MD4, 8'h03); wr(A_MD1, 8'h00); wr(A_MD5, 8'h00);
    wait_op();
    chk32(32'h0000_0060, "R4 product after restart");

    // R10: final read disarms monitoring
    wr(A_MD0, 8'h01);
    rd(A_CTL, 8'h00, "R10 no error after final read");

    // R12: unknown order starts nothing
    wr(A_MD0, 8'h11); wr(A_MD2, 8'h22); wr(A_MD1, 8'h33); wr(A_MD5, 8'h44);
    wait_op();
    rd(A_MD0, 8'h11, "R12 byte kept");
    rd(A_MD1, 8'h33, "R12 byte kept");
    rd(A_MD2, 8'h22, "R12 byte kept");
    rd(A_MD5, 8'h44, "R12 byte kept");
    rd(A_CTL, 8'h80, "R12 no op started, restart flagged");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule